// File: doc/BRIEF.md
# ADC Channel-List Scan Sequencer

This block runs a multiplexed analog-to-digital converter from a programmed scan list. Each list entry holds a channel number and a gain code. Software fills the list and selects a list length, a pacing mode, a pacing-tick source and a single-ended or differential input arrangement. It then starts the scan and later stops it. For each conversion the block drives the multiplexer select, the return-line select and the gain code, and pulses a convert strobe. When the converter reports completion, the result is pushed into a sample FIFO together with the list index it belongs to.

There are two pacing modes. In step mode each pacing tick converts one list entry, and the position carries over from one tick to the next. In burst mode each pacing tick converts the whole list back to back, as fast as the converter completes. The pacing tick comes from an internal tick, from a synchronised external clock edge, or from either of these qualified by a synchronised external gate. The status outputs are busy, a rejected-configuration flag, a pacing-overrun flag and a FIFO-overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: Conversions follow list order. Each strobe uses the entry at the current list index. The FIFO word is `{index[5:0], result[11:0]}`, with the index in the upper bits, and is visible at `fifo_data_o` whenever `fifo_empty_o` is low. `fifo_pop_i` removes that word.
- R2: Each entry's 2-bit gain code goes unchanged to `adc_gain_o` for that entry's conversion. Code 0 is x1, 1 is x10, 2 is x100 and 3 is x1000.
- R3: A start while idle with `cfg_len_i` equal to 0 or greater than 64 is refused. `cfg_err_o` goes to 1 and `busy_o` stays 0. A start with a length from 1 to 64 is accepted and clears `cfg_err_o`. `clr_i` also clears `cfg_err_o`.
- R4: In step mode (`cfg_burst_i`=0) each pacing tick converts exactly one entry. The index advances by one per conversion and returns to 0 after entry length-1. An accepted start always begins at index 0.
- R5: In burst mode (`cfg_burst_i`=1) each pacing tick converts entries 0 to length-1 in order. Each strobe after the first in a pass is issued in the cycle right after the previous completion.
- R6: The source code selects the pacing tick. 0 is the internal tick qualified by the gate, 1 is the internal tick only, 2 is a rising edge of the external clock, and 3 is that edge qualified by the gate. A candidate tick that the selected source does not pass causes no conversion.
- R7: With `cfg_diff_i`=1, entry channel c drives `adc_mux_o` = c mod 8 and `adc_ret_o` = (c mod 8) + 8. With `cfg_diff_i`=0, `adc_mux_o` = c and `adc_ret_o` = 0.
- R8: A pacing tick that arrives while a conversion or burst pass is still in progress is discarded and sets `pace_ovr_o`. The flag stays set until a stop or `clr_i`.
- R9: A completion while the FIFO is full drops that result and sets `fifo_ovr_o`. The flag stays set until a stop or `clr_i`, and stored words are kept.
- R10: `busy_o` rises on an accepted start and falls only on a stop. A conversion already in flight at the stop still completes and its result is stored. No new strobe is issued after the stop, and a start before that completion is ignored.
- R11: List writes made while `busy_o` is 1 are ignored. Writes made while idle take effect.

Top module parameters: `LIST_DEPTH` (64), `CHAN_W` (5), `GAIN_W` (2), `DATA_W` (12), `FIFO_DEPTH` (2048), `PAIR_W` (3), `SYNC_STAGES` (2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| list_we_i | input | 1 | List entry write enable |
| list_addr_i | input | 6 | List entry address |
| list_chan_i | input | 5 | Channel number to store |
| list_gain_i | input | 2 | Gain code to store |
| cfg_len_i | input | 8 | List length used by a start |
| cfg_burst_i | input | 1 | 1 selects burst mode, 0 selects step mode |
| cfg_src_i | input | 2 | Pacing source code |
| cfg_diff_i | input | 1 | Differential pairing enable |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| clr_i | input | 1 | Clears the sticky flags |
| int_tick_i | input | 1 | Internal pacing tick, one cycle wide |
| ext_clk_i | input | 1 | External pacing clock, asynchronous |
| ext_gate_i | input | 1 | External gate, asynchronous |
| adc_conv_o | output | 1 | Convert strobe, one cycle wide |
| adc_mux_o | output | 5 | Positive input select |
| adc_ret_o | output | 5 | Return input select |
| adc_gain_o | output | 2 | Gain code |
| adc_done_i | input | 1 | Conversion-done pulse |
| adc_data_i | input | 12 | Conversion result |
| fifo_pop_i | input | 1 | Removes the head FIFO word |
| fifo_data_o | output | 18 | Head FIFO word `{index, result}` |
| fifo_empty_o | output | 1 | FIFO empty |
| busy_o | output | 1 | Scan active |
| cfg_err_o | output | 1 | Refused configuration, sticky |
| pace_ovr_o | output | 1 | Pacing overrun, sticky |
| fifo_ovr_o | output | 1 | FIFO overrun, sticky |

## Verification
A wrong list index shows up in the tag of the very next FIFO word and in the select lines of the next strobe. In burst mode it also changes the number of results a pass produces, which is visible as soon as the pass ends. A wrong sequencer state shows up as a missing or extra convert strobe within one cycle of a tick or completion, or as `busy_o` moving without a stop. A lost overrun or drain condition shows up as a flag that clears early or a result count that is off by one when the FIFO is emptied after the stop.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Pacing source codes. The encoding is visible to software.
  typedef enum logic [1:0] {
    SRC_INT_GATED = 2'd0,
    SRC_INT       = 2'd1,
    SRC_EXT       = 2'd2,
    SRC_EXT_GATED = 2'd3
  } pace_src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT,
    ST_DRAIN
  } seq_st_e;

endpackage

// File: rtl/adc_scan_pacer.sv
module adc_scan_pacer
  import adc_scan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pace_src_e src_i,
  input  logic      enable_i,
  input  logic      int_tick_i,
  input  logic      ext_clk_i,
  input  logic      ext_gate_i,
  output logic      tick_o
);

  logic [SYNC_STAGES:0]   clk_sh_q;
  logic [SYNC_STAGES-1:0] gate_sh_q;
  logic ext_rise, gate_s, raw_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh_q  <= '0;
      gate_sh_q <= '0;
    end else begin
      clk_sh_q  <= {clk_sh_q[SYNC_STAGES-1:0], ext_clk_i};
      gate_sh_q <= {gate_sh_q[SYNC_STAGES-2:0], ext_gate_i};
    end
  end

  assign ext_rise = clk_sh_q[SYNC_STAGES-1] & ~clk_sh_q[SYNC_STAGES];
  assign gate_s   = gate_sh_q[SYNC_STAGES-1];

  always_comb begin
    case (src_i)
      SRC_INT_GATED: raw_tick = int_tick_i & gate_s;
      SRC_INT:       raw_tick = int_tick_i;
      SRC_EXT:       raw_tick = ext_rise;
      default:       raw_tick = ext_rise & gate_s;
    endcase
  end

  assign tick_o = enable_i & raw_tick;

  // R6
  ext_edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise);

endmodule

// File: rtl/adc_scan_list.sv
module adc_scan_list #(
  parameter int DEPTH  = 64,
  parameter int CHAN_W = 5,
  parameter int GAIN_W = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [CHAN_W-1:0] wchan_i,
  input  logic [GAIN_W-1:0] wgain_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [CHAN_W-1:0] rchan_o,
  output logic [GAIN_W-1:0] rgain_o
);

  logic [CHAN_W-1:0] chan_mem [DEPTH];
  logic [GAIN_W-1:0] gain_mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        chan_mem[i] <= '0;
        gain_mem[i] <= '0;
      end
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      chan_mem[waddr_i] <= wchan_i;
      gain_mem[waddr_i] <= wgain_i;
    end
  end

  assign rchan_o = chan_mem[raddr_i];
  assign rgain_o = gain_mem[raddr_i];

endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
  parameter int DEPTH = 2048,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic wr_en, rd_en;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_en   = push_i & ~full_o;
  assign rd_en   = pop_i & ~empty_o;
  assign data_o  = mem[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_en) rd_ptr_q <= nxt(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  fifo_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R9
  fifo_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int LIST_DEPTH  = 64,
  parameter int CHAN_W      = 5,
  parameter int GAIN_W      = 2,
  parameter int DATA_W      = 12,
  parameter int FIFO_DEPTH  = 2048,
  parameter int PAIR_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int LIST_AW    = $clog2(LIST_DEPTH),
  localparam int LEN_W      = $clog2(LIST_DEPTH) + 2,
  localparam int TAG_W      = LIST_AW + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               list_we_i,
  input  logic [LIST_AW-1:0] list_addr_i,
  input  logic [CHAN_W-1:0]  list_chan_i,
  input  logic [GAIN_W-1:0]  list_gain_i,
  input  logic [LEN_W-1:0]   cfg_len_i,
  input  logic               cfg_burst_i,
  input  logic [1:0]         cfg_src_i,
  input  logic               cfg_diff_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               clr_i,
  input  logic               int_tick_i,
  input  logic               ext_clk_i,
  input  logic               ext_gate_i,
  output logic               adc_conv_o,
  output logic [CHAN_W-1:0]  adc_mux_o,
  output logic [CHAN_W-1:0]  adc_ret_o,
  output logic [GAIN_W-1:0]  adc_gain_o,
  input  logic               adc_done_i,
  input  logic [DATA_W-1:0]  adc_data_i,
  input  logic               fifo_pop_i,
  output logic [TAG_W-1:0]   fifo_data_o,
  output logic               fifo_empty_o,
  output logic               busy_o,
  output logic               cfg_err_o,
  output logic               pace_ovr_o,
  output logic               fifo_ovr_o
);

  localparam int PAIR_OFS = 1 << PAIR_W;

  seq_st_e            state_q;
  pace_src_e          src_q;
  logic               run_q, burst_q, diff_q, conv_q;
  logic               err_q, povr_q, fovr_q;
  logic [LIST_AW-1:0] idx_q, issue_idx;
  logic [LEN_W-1:0]   len_q;
  logic [CHAN_W-1:0]  mux_q, ret_q, rd_chan, map_mux, map_ret;
  logic [GAIN_W-1:0]  gain_q, rd_gain;
  logic               tick, issue_en, last, len_ok, push, fifo_full;

  adc_scan_pacer #(.SYNC_STAGES(SYNC_STAGES)) pacer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_q),
    .enable_i   (run_q),
    .int_tick_i (int_tick_i),
    .ext_clk_i  (ext_clk_i),
    .ext_gate_i (ext_gate_i),
    .tick_o     (tick)
  );

  adc_scan_list #(.DEPTH(LIST_DEPTH), .CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) list_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (list_we_i & ~run_q),
    .waddr_i (list_addr_i),
    .wchan_i (list_chan_i),
    .wgain_i (list_gain_i),
    .raddr_i (issue_idx),
    .rchan_o (rd_chan),
    .rgain_o (rd_gain)
  );

  assign push = adc_done_i & ((state_q == ST_WAIT) | (state_q == ST_DRAIN));

  adc_scan_fifo #(.DEPTH(FIFO_DEPTH), .W(TAG_W)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({idx_q, adc_data_i}),
    .pop_i   (fifo_pop_i),
    .data_o  (fifo_data_o),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full)
  );

  assign len_ok = (cfg_len_i != '0) && (cfg_len_i <= LEN_W'(LIST_DEPTH));
  assign last   = (LEN_W'(idx_q) == len_q - LEN_W'(1));

  // Next entry to convert, if any, this cycle.
  always_comb begin
    issue_en  = 1'b0;
    issue_idx = idx_q;
    if (state_q == ST_ARMED && !stop_i && tick) begin
      issue_en  = 1'b1;
      issue_idx = burst_q ? '0 : idx_q;
    end else if (state_q == ST_WAIT && !stop_i && adc_done_i && burst_q && !last) begin
      issue_en  = 1'b1;
      issue_idx = idx_q + LIST_AW'(1);
    end
  end

  // Differential pairing: positive n, return n + 2**PAIR_W.
  assign map_mux = diff_q ? CHAN_W'(rd_chan[PAIR_W-1:0]) : rd_chan;
  assign map_ret = diff_q ? CHAN_W'(rd_chan[PAIR_W-1:0]) + CHAN_W'(PAIR_OFS) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_INT;
      run_q   <= 1'b0;
      burst_q <= 1'b0;
      diff_q  <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      conv_q  <= 1'b0;
      mux_q   <= '0;
      ret_q   <= '0;
      gain_q  <= '0;
      err_q   <= 1'b0;
      povr_q  <= 1'b0;
      fovr_q  <= 1'b0;
    end else begin
      conv_q <= 1'b0;
      if (issue_en) begin
        conv_q <= 1'b1;
        mux_q  <= map_mux;
        ret_q  <= map_ret;
        gain_q <= rd_gain;
        idx_q  <= issue_idx;
      end
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (len_ok) begin
              state_q <= ST_ARMED;
              run_q   <= 1'b1;
              len_q   <= cfg_len_i;
              burst_q <= cfg_burst_i;
              diff_q  <= cfg_diff_i;
              src_q   <= pace_src_e'(cfg_src_i);
              idx_q   <= '0;
              err_q   <= 1'b0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_ARMED: begin
          if (stop_i) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
          end else if (tick) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (stop_i) begin
            run_q   <= 1'b0;
            state_q <= adc_done_i ? ST_IDLE : ST_DRAIN;
          end else begin
            if (tick) povr_q <= 1'b1;
            if (adc_done_i && !issue_en) begin
              state_q <= ST_ARMED;
              idx_q   <= last ? '0 : idx_q + LIST_AW'(1);
            end
          end
        end
        default: begin
          if (adc_done_i) state_q <= ST_IDLE;
        end
      endcase
      if (push && fifo_full) fovr_q <= 1'b1;
      if (stop_i) begin
        povr_q <= 1'b0;
        fovr_q <= 1'b0;
      end
      if (clr_i) begin
        err_q  <= 1'b0;
        povr_q <= 1'b0;
        fovr_q <= 1'b0;
      end
    end
  end

  assign adc_conv_o = conv_q;
  assign adc_mux_o  = mux_q;
  assign adc_ret_o  = ret_q;
  assign adc_gain_o = gain_q;
  assign busy_o     = run_q;
  assign cfg_err_o  = err_q;
  assign pace_ovr_o = povr_q;
  assign fifo_ovr_o = fovr_q;

  // R5
  conv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |=> !adc_conv_o);

  // R10
  conv_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |-> busy_o);

  // R10
  busy_fall_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(stop_i));

  // R3
  err_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> !busy_o);

  // R8
  pace_ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pace_ovr_o && !stop_i && !clr_i |=> pace_ovr_o);

  // R9
  fifo_ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovr_o && !stop_i && !clr_i |=> fifo_ovr_o);

  // R7
  diff_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o && diff_q |-> adc_ret_o == adc_mux_o + CHAN_W'(PAIR_OFS));

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

  localparam int FIFO_DEPTH = 16;
  localparam int LAT        = 4;

  logic        clk, rst_ni;
  logic        list_we_i;
  logic [5:0]  list_addr_i;
  logic [4:0]  list_chan_i;
  logic [1:0]  list_gain_i;
  logic [7:0]  cfg_len_i;
  logic        cfg_burst_i, cfg_diff_i;
  logic [1:0]  cfg_src_i;
  logic        start_i, stop_i, clr_i, int_tick_i, ext_clk_i, ext_gate_i;
  logic        adc_conv_o, adc_done_i;
  logic [4:0]  adc_mux_o, adc_ret_o;
  logic [1:0]  adc_gain_o;
  logic [11:0] adc_data_i;
  logic        fifo_pop_i, fifo_empty_o;
  logic [17:0] fifo_data_o;
  logic        busy_o, cfg_err_o, pace_ovr_o, fifo_ovr_o;

  int n_chk, n_err;
  int m_chan [64];
  int m_gain [64];
  int conv_cnt, b2b_cnt, pend;
  logic last_done;
  logic [11:0] cap;

  adc_scan_seq #(.FIFO_DEPTH(FIFO_DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .list_we_i(list_we_i), .list_addr_i(list_addr_i),
    .list_chan_i(list_chan_i), .list_gain_i(list_gain_i),
    .cfg_len_i(cfg_len_i), .cfg_burst_i(cfg_burst_i),
    .cfg_src_i(cfg_src_i), .cfg_diff_i(cfg_diff_i),
    .start_i(start_i), .stop_i(stop_i), .clr_i(clr_i),
    .int_tick_i(int_tick_i), .ext_clk_i(ext_clk_i), .ext_gate_i(ext_gate_i),
    .adc_conv_o(adc_conv_o), .adc_mux_o(adc_mux_o), .adc_ret_o(adc_ret_o),
    .adc_gain_o(adc_gain_o), .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .fifo_pop_i(fifo_pop_i), .fifo_data_o(fifo_data_o), .fifo_empty_o(fifo_empty_o),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o), .pace_ovr_o(pace_ovr_o), .fifo_ovr_o(fifo_ovr_o)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  // Converter model: result encodes the selects seen at the strobe.
  initial begin
    adc_done_i = 1'b0; adc_data_i = '0; pend = 0;
    conv_cnt = 0; b2b_cnt = 0; last_done = 1'b0; cap = '0;
    forever begin
      @(negedge clk);
      last_done  = adc_done_i;
      adc_done_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_done_i = 1'b1;
          adc_data_i = cap;
        end
      end
      if (adc_conv_o) begin
        conv_cnt++;
        if (last_done) b2b_cnt++;
        cap  = {adc_ret_o, adc_mux_o, adc_gain_o};
        pend = LAT;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lwrite(int a, int c, int g, bit mirror);
    list_we_i = 1'b1; list_addr_i = 6'(a); list_chan_i = 5'(c); list_gain_i = 2'(g);
    @(negedge clk);
    list_we_i = 1'b0;
    if (mirror) begin
      m_chan[a] = c;
      m_gain[a] = g;
    end
  endtask

  task automatic do_start(int len, bit burst, int src, bit diff);
    cfg_len_i = 8'(len); cfg_burst_i = burst; cfg_src_i = 2'(src); cfg_diff_i = diff;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic do_clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic tick(int gap);
    int_tick_i = 1'b1;
    @(negedge clk);
    int_tick_i = 1'b0;
    wcyc(gap);
  endtask

  task automatic ext_pulse();
    ext_clk_i = 1'b1;
    wcyc(5);
    ext_clk_i = 1'b0;
    wcyc(15);
  endtask

  function automatic logic [17:0] exp_word(int idx, bit diff);
    logic [4:0] c, mux, ret;
    c = 5'(m_chan[idx]);
    if (diff) begin
      mux = {2'b00, c[2:0]};
      ret = mux + 5'd8;
    end else begin
      mux = c;
      ret = '0;
    end
    return {6'(idx), ret, mux, 2'(m_gain[idx])};
  endfunction

  task automatic drain(int n, int len, bit diff, string req);
    for (int k = 0; k < n; k++) begin
      check(req, fifo_data_o, exp_word(k % len, diff));
      fifo_pop_i = 1'b1;
      @(negedge clk);
      fifo_pop_i = 1'b0;
    end
    check({req, " empty after drain"}, fifo_empty_o, 1);
  endtask

  initial begin
    #500us;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int c0, b0, len;
    n_chk = 0; n_err = 0;
    rst_ni = 1'b0;
    list_we_i = 0; list_addr_i = '0; list_chan_i = '0; list_gain_i = '0;
    cfg_len_i = '0; cfg_burst_i = 0; cfg_src_i = 2'd1; cfg_diff_i = 0;
    start_i = 0; stop_i = 0; clr_i = 0; int_tick_i = 0; ext_clk_i = 0; ext_gate_i = 0;
    fifo_pop_i = 0;
    void'($urandom(32'd20240613));
    wcyc(3);
    rst_ni = 1'b1;
    wcyc(1);

    // Reset state, R10 / R1
    check("R10 busy after reset", busy_o, 0);
    check("R1 fifo empty after reset", fifo_empty_o, 1);
    check("R3 err after reset", cfg_err_o, 0);
    check("R8 pace ovr after reset", pace_ovr_o, 0);
    check("R9 fifo ovr after reset", fifo_ovr_o, 0);

    for (int a = 0; a < 64; a++) lwrite(a, $urandom_range(31, 0), $urandom_range(3, 0), 1);
    lwrite(0, 13, 3, 1);
    lwrite(1, 7, 0, 1);
    lwrite(2, 8, 1, 1);
    lwrite(3, 31, 2, 1);

    // R3: length bounds
    do_start(0, 0, 1, 0);
    check("R3 len 0 sets err", cfg_err_o, 1);
    check("R3 len 0 not busy", busy_o, 0);
    do_clr();
    check("R3 clr clears err", cfg_err_o, 0);
    do_start(65, 0, 1, 0);
    check("R3 len 65 sets err", cfg_err_o, 1);
    check("R3 len 65 not busy", busy_o, 0);
    c0 = conv_cnt;
    tick(10);
    check("R3 no conversion when refused", conv_cnt - c0, 0);
    do_start(64, 0, 1, 0);
    check("R3 len 64 accepted", busy_o, 1);
    check("R3 accepted start clears err", cfg_err_o, 0);
    for (int t = 0; t < 3; t++) tick(10);
    do_stop();
    wcyc(8);
    drain(3, 64, 0, "R3 len 64 samples");

    // R4 / R1 / R2: step mode, random length
    len = $urandom_range(6, 3);
    c0 = conv_cnt; b0 = b2b_cnt;
    do_start(len, 0, 1, 0);
    for (int t = 0; t < 12; t++) tick(10);
    check("R4 one conversion per tick", conv_cnt - c0, 12);
    check("R4 no back-to-back in step mode", b2b_cnt - b0, 0);
    do_stop();
    wcyc(8);
    drain(12, len, 0, "R4 R1 R2 step order and gain");
    do_start(len, 0, 1, 0);
    for (int t = 0; t < 2; t++) tick(10);
    do_stop();
    wcyc(8);
    drain(2, len, 0, "R4 restart at index 0");

    // R5 / R7: burst, differential
    c0 = conv_cnt; b0 = b2b_cnt;
    do_start(6, 1, 1, 1);
    tick(60);
    tick(60);
    check("R5 full pass per tick", conv_cnt - c0, 12);
    check("R5 back-to-back strobes", b2b_cnt - b0, 10);
    check("R8 no overrun with slow ticks", pace_ovr_o, 0);
    do_stop();
    wcyc(4);
    drain(12, 6, 1, "R5 R7 burst diff words");

    // R6: source selection
    ext_gate_i = 0;
    do_start(4, 0, 0, 0);
    wcyc(5);
    c0 = conv_cnt;
    for (int t = 0; t < 3; t++) tick(10);
    check("R6 src0 gate low blocks", conv_cnt - c0, 0);
    ext_gate_i = 1;
    wcyc(5);
    for (int t = 0; t < 3; t++) tick(10);
    check("R6 src0 gate high passes", conv_cnt - c0, 3);
    do_stop();
    wcyc(4);
    drain(3, 4, 0, "R6 src0 words");

    do_start(4, 0, 2, 0);
    c0 = conv_cnt;
    for (int t = 0; t < 2; t++) tick(10);
    check("R6 src2 ignores internal tick", conv_cnt - c0, 0);
    for (int t = 0; t < 3; t++) ext_pulse();
    check("R6 src2 ext edges", conv_cnt - c0, 3);
    do_stop();
    wcyc(4);
    drain(3, 4, 0, "R6 src2 words");

    ext_gate_i = 0;
    do_start(4, 0, 3, 0);
    wcyc(5);
    c0 = conv_cnt;
    for (int t = 0; t < 2; t++) ext_pulse();
    check("R6 src3 gate low blocks", conv_cnt - c0, 0);
    ext_gate_i = 1;
    wcyc(5);
    for (int t = 0; t < 2; t++) ext_pulse();
    check("R6 src3 gate high passes", conv_cnt - c0, 2);
    do_stop();
    ext_gate_i = 0;
    wcyc(4);
    drain(2, 4, 0, "R6 src3 words");

    // R8: pacing overrun
    c0 = conv_cnt;
    do_start(8, 1, 1, 0);
    tick(10);
    tick(80);
    check("R8 overrun flagged", pace_ovr_o, 1);
    check("R8 second tick discarded", conv_cnt - c0, 8);
    wcyc(20);
    check("R8 overrun sticky", pace_ovr_o, 1);
    do_clr();
    check("R8 clr clears overrun", pace_ovr_o, 0);
    check("R8 clr keeps busy", busy_o, 1);
    tick(10);
    tick(80);
    check("R8 overrun set again", pace_ovr_o, 1);
    do_stop();
    check("R8 stop clears overrun", pace_ovr_o, 0);
    wcyc(4);
    drain(16, 8, 0, "R8 pass words");

    // R9: FIFO overrun
    do_start(3, 0, 1, 0);
    for (int t = 0; t < 20; t++) tick(10);
    check("R9 fifo overrun flagged", fifo_ovr_o, 1);
    do_clr();
    check("R9 clr clears fifo ovr", fifo_ovr_o, 0);
    tick(10);
    check("R9 fifo overrun set again", fifo_ovr_o, 1);
    do_stop();
    check("R9 stop clears fifo ovr", fifo_ovr_o, 0);
    wcyc(4);
    drain(16, 3, 0, "R9 kept words");

    // R10: stop with a conversion in flight
    do_start(2, 0, 1, 0);
    check("R10 busy after start", busy_o, 1);
    c0 = conv_cnt;
    tick(1);
    do_stop();
    check("R10 busy low after stop", busy_o, 0);
    do_start(2, 0, 1, 0);
    check("R10 start ignored while draining", busy_o, 0);
    wcyc(10);
    check("R10 in-flight conversion only", conv_cnt - c0, 1);
    drain(1, 2, 0, "R10 in-flight result stored");
    do_start(2, 0, 1, 0);
    check("R10 start after drain accepted", busy_o, 1);
    do_stop();

    // R11: list writes while busy
    do_start(1, 0, 1, 0);
    lwrite(0, 22, 1, 0);
    tick(10);
    do_stop();
    wcyc(4);
    drain(1, 1, 0, "R11 busy write ignored");
    lwrite(0, 22, 1, 1);
    do_start(1, 0, 1, 0);
    tick(10);
    do_stop();
    wcyc(4);
    drain(1, 1, 0, "R11 idle write applied");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule